// File: doc/BRIEF.md
# Cascadable Quad 16-bit Timer Array

This block contains four 16-bit general-purpose timers that share one register bus. Each timer has a counter, a reference value, a capture value, a mode word and an event word. Two configuration words decide how the timers chain. Timers 1 and 2 can fuse into a 32-bit timer, and so can timers 3 and 4. Each of the two pairs chains on its own. A separate all-chain bit fuses all four timers into one 64-bit timer. When timers are chained, the highest-numbered member of the group governs the whole group: its mode word sets the run, capture-edge and interrupt-enable controls, its capture pin triggers the capture, and its event word collects the flags.

Counting advances on a single enable input, `tick`. On a tick where the whole group's counter equals its whole reference value, the counter restarts at zero and the reference flag is raised. A capture edge copies the full group counter into the capture registers of every member in one cycle. In a chained group, one 32-bit bus word carries the lower-numbered timer in bits [31:16] and the higher-numbered one in bits [15:0]. A 64-bit group is accessed as two such words.

Top module: `gptimer_quad`

## Requirements
- R1: After reset every counter, reference, capture, mode, event and configuration field reads zero and all four interrupt outputs are low.
- R2: With no chaining, a timer whose mode bit 0 (run) is set increments by one on each cycle with `tick` high, wraps from 0xFFFF to 0x0000 without raising a flag, and leaves the other timers untouched.
- R3: Configuration word 0 bit 0 chains timers 1 and 2. Configuration word 1 bit 0 chains timers 3 and 4. In a chained pair the upper-numbered timer is the low half, and the lower-numbered timer increments only on a tick where the low half rolls over from 0xFFFF. The two pairs chain independently.
- R4: Configuration word 1 bit 1 chains all four timers, with timer 4 as the least significant half and timer 1 as the most significant. A carry passes up through every half that is at 0xFFFF in the same cycle.
- R5: In a chained group only the highest-numbered member's mode word takes effect. The other members' mode words have no effect. When all four are chained, configuration word 0 also has no effect.
- R6: A reference match compares the whole group width. On a tick with the group running and an exact match, the group counter becomes zero and event bit 0 of the governing timer is set. A match in some halves only does not restart the counter.
- R7: An edge on the governing timer's capture pin copies the full group counter into all members' capture registers in the same cycle and sets event bit 1 of the governing timer. The edge is rising when mode bit 1 is 0 and falling when it is 1. Pins of non-governing timers have no effect.
- R8: Register addresses are {class[2:0], timer[1:0]}, where timer 0 to 3 stands for timers 1 to 4 and class is 0 config, 1 mode, 2 event, 3 reference, 4 capture or 5 counter. Reference, capture and counter accesses that address timer 1 while timers 1/2 are chained, or timer 3 while timers 3/4 are chained (or all four are chained), carry the addressed timer in bits [31:16] and the next timer in bits [15:0]. All other accesses use bits [15:0] and read zero above.
- R9: Writing 1 to an event bit clears it, and a flag raised in the same cycle wins. Interrupt output i is high only when timer i governs its group, its mode bit 2 (interrupt enable) is set and one of its event bits is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| cap_pin | input | 4 | Capture inputs, bit i for timer i+1 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address {class, timer} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 4 | Interrupt per timer, bit i for timer i+1 |

## Verification
The hardest situation to reach is a carry that crosses several halves at once in the 64-bit chain, together with a group match that needs every half equal at the same moment. From reset these would take billions of ticks. The stimulus uses wide counter writes to preload values just below a 16-bit and a 48-bit boundary, then issues a few ticks. It also loads a reference whose halves equal the counter one at a time, to show that a partial match does not restart the counter. Capture is driven on both governing and non-governing pins with each edge polarity, so that ignored edges can be told apart from real ones.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int NTMR   = 4;
    localparam int TSEL_W = 2;
    localparam int ADDR_W = TSEL_W + 3;

    typedef enum logic [2:0] {
        RC_CFG  = 3'd0,
        RC_MODE = 3'd1,
        RC_EVT  = 3'd2,
        RC_REF  = 3'd3,
        RC_CAP  = 3'd4,
        RC_CNT  = 3'd5
    } reg_cls_e;

    // mode word: bit2 irq enable, bit1 capture on falling edge, bit0 run
    typedef struct packed {
        logic irq_en;
        logic cap_fall;
        logic run;
    } mode_t;

    // event word: bit1 capture seen, bit0 reference match
    typedef struct packed {
        logic cap;
        logic refm;
    } evt_t;
endpackage

// File: rtl/gpt_cascade_ctrl.sv
module gpt_cascade_ctrl
    import gpt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_lo,
    input  logic                    wr_hi,
    input  logic [1:0]              wbits,
    output logic                    pair_lo,
    output logic                    pair_hi,
    output logic                    chain_all,
    output logic [NTMR-1:0][1:0]    gov,
    output logic [NTMR-2:0]         link,
    output logic [NTMR-1:0]         wide
);
    typedef struct packed {
        logic pair_lo;
        logic pair_hi;
        logic all;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_lo) cfg_d.pair_lo = wbits[0];
        if (wr_hi) begin
            cfg_d.pair_hi = wbits[0];
            cfg_d.all     = wbits[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign pair_lo   = cfg_q.pair_lo;
    assign pair_hi   = cfg_q.pair_hi;
    assign chain_all = cfg_q.all;

    always_comb begin
        for (int i = 0; i < NTMR; i++) begin
            if (cfg_q.all)           gov[i] = 2'd3;
            else if (i < 2)          gov[i] = cfg_q.pair_lo ? 2'd1 : 2'(i);
            else                     gov[i] = cfg_q.pair_hi ? 2'd3 : 2'(i);
        end
        link[0] = cfg_q.all | cfg_q.pair_lo;
        link[1] = cfg_q.all;
        link[2] = cfg_q.all | cfg_q.pair_hi;
        wide[0] = link[0];
        wide[1] = 1'b0;
        wide[2] = link[2];
        wide[3] = 1'b0;
    end
endmodule

// File: rtl/gpt_segment.sv
module gpt_segment
    import gpt_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             restart,
    input  logic             cap_load,
    input  logic             set_ref,
    input  logic             set_cap,
    input  logic             wr_mode,
    input  mode_t            mode_wd,
    input  logic             wr_evt,
    input  logic [1:0]       evt_clr,
    input  logic             wr_ref,
    input  logic             wr_cnt,
    input  logic [SEG_W-1:0] wd,
    output logic [SEG_W-1:0] cnt_o,
    output logic [SEG_W-1:0] ref_o,
    output logic [SEG_W-1:0] cap_o,
    output mode_t            mode_o,
    output evt_t             evt_o
);
    typedef struct packed {
        logic [SEG_W-1:0] cnt;
        logic [SEG_W-1:0] refv;
        logic [SEG_W-1:0] cap;
        mode_t            mode;
        evt_t             evt;
    } seg_t;

    seg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_mode)  s_d.mode = mode_wd;
        if (wr_ref)   s_d.refv = wd;
        if (cap_load) s_d.cap  = s_q.cnt;
        if (wr_cnt)       s_d.cnt = wd;
        else if (restart) s_d.cnt = '0;
        else if (inc)     s_d.cnt = s_q.cnt + SEG_W'(1);
        if (wr_evt)   s_d.evt = evt_t'(s_q.evt & ~evt_clr);
        if (set_ref)  s_d.evt.refm = 1'b1;
        if (set_cap)  s_d.evt.cap  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o  = s_q.cnt;
    assign ref_o  = s_q.refv;
    assign cap_o  = s_q.cap;
    assign mode_o = s_q.mode;
    assign evt_o  = s_q.evt;

    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !restart && !wr_cnt) |=> (cnt_o == $past(cnt_o) + SEG_W'(1)));

    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !wr_cnt) |=> (cnt_o == '0));

    a_r7_capture_copy: assert property (@(posedge clk) disable iff (!rst_n)
        cap_load |=> (cap_o == $past(cnt_o)));

    a_r9_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && !set_ref && !set_cap) |=> ((evt_o & $past(evt_clr)) == 2'b00));
endmodule

// File: rtl/gptimer_quad.sv
module gptimer_quad
    import gpt_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [NTMR-1:0]     cap_pin,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*SEG_W-1:0]  bus_wdata,
    output logic [2*SEG_W-1:0]  bus_rdata,
    output logic [NTMR-1:0]     irq
);
    localparam int BUS_W = 2 * SEG_W;

    typedef struct packed {
        logic [NTMR-1:0] pin_prev;
    } top_t;

    top_t t_d, t_q;

    logic [TSEL_W-1:0]   tsel;
    logic [TSEL_W-1:0]   tsel_hi;
    reg_cls_e            cls;
    logic                pair_lo, pair_hi, chain_all;
    logic [NTMR-1:0][1:0] gov;
    logic [NTMR-2:0]     link;
    logic [NTMR-1:0]     wide;

    logic [SEG_W-1:0]    cnt_v [NTMR];
    logic [SEG_W-1:0]    ref_v [NTMR];
    logic [SEG_W-1:0]    cap_v [NTMR];
    mode_t               mode_v [NTMR];
    evt_t                evt_v [NTMR];

    logic [NTMR-1:0]     is_gov, eq, grp_eq, cin, step, restart, inc;
    logic [NTMR-1:0]     edge_hit, cap_load, set_ref, set_cap;
    logic [NTMR-1:0]     wr_mode, wr_evt, wr_ref, wr_cnt, sel_wide;
    logic [SEG_W-1:0]    seg_wd [NTMR];
    logic                wr_cfg_lo, wr_cfg_hi;

    assign tsel    = bus_addr[TSEL_W-1:0];
    assign tsel_hi = {tsel[1], 1'b1};
    assign cls     = reg_cls_e'(bus_addr[ADDR_W-1:TSEL_W]);

    assign wr_cfg_lo = bus_wr && (cls == RC_CFG) && (tsel == 2'd0);
    assign wr_cfg_hi = bus_wr && (cls == RC_CFG) && (tsel == 2'd1);

    gpt_cascade_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_cfg_lo),
        .wr_hi     (wr_cfg_hi),
        .wbits     (bus_wdata[1:0]),
        .pair_lo   (pair_lo),
        .pair_hi   (pair_hi),
        .chain_all (chain_all),
        .gov       (gov),
        .link      (link),
        .wide      (wide)
    );

    // ---------------- bus write steering ----------------
    always_comb begin
        for (int i = 0; i < NTMR; i++) begin
            sel_wide[i] = wide[tsel] && ((tsel == 2'(i)) || (tsel_hi == 2'(i)));
            if (wide[tsel] && (tsel == 2'(i)))
                seg_wd[i] = bus_wdata[BUS_W-1:SEG_W];
            else
                seg_wd[i] = bus_wdata[SEG_W-1:0];
            wr_mode[i] = bus_wr && (cls == RC_MODE) && (tsel == 2'(i));
            wr_evt[i]  = bus_wr && (cls == RC_EVT)  && (tsel == 2'(i));
            wr_ref[i]  = bus_wr && (cls == RC_REF) && ((tsel == 2'(i)) || sel_wide[i]);
            wr_cnt[i]  = bus_wr && (cls == RC_CNT) && ((tsel == 2'(i)) || sel_wide[i]);
        end
    end

    // ---------------- cascade counting, match, capture ----------------
    always_comb begin
        for (int i = 0; i < NTMR; i++) begin
            is_gov[i] = (gov[i] == 2'(i));
            eq[i]     = (cnt_v[i] == ref_v[i]);
        end
        for (int i = 0; i < NTMR; i++) begin
            grp_eq[i] = 1'b1;
            for (int j = 0; j < NTMR; j++) begin
                if ((gov[j] == 2'(i)) && !eq[j]) grp_eq[i] = 1'b0;
            end
        end
    end

    // carry enters each half from the half below it (timer i+1)
    assign cin[3] = 1'b1;
    assign cin[2] = link[2] ? (cin[3] && (cnt_v[3] == '1)) : 1'b1;
    assign cin[1] = link[1] ? (cin[2] && (cnt_v[2] == '1)) : 1'b1;
    assign cin[0] = link[0] ? (cin[1] && (cnt_v[1] == '1)) : 1'b1;

    always_comb begin
        for (int i = 0; i < NTMR; i++) begin
            if (mode_v[i].cap_fall)
                edge_hit[i] = t_q.pin_prev[i] && !cap_pin[i];
            else
                edge_hit[i] = !t_q.pin_prev[i] && cap_pin[i];
        end
        for (int i = 0; i < NTMR; i++) begin
            step[i]     = tick && mode_v[gov[i]].run;
            restart[i]  = step[i] && grp_eq[gov[i]];
            inc[i]      = step[i] && cin[i];
            set_ref[i]  = is_gov[i] && step[i] && grp_eq[i];
            cap_load[i] = edge_hit[gov[i]];
            set_cap[i]  = is_gov[i] && edge_hit[i];
        end
    end

    always_comb begin
        t_d          = t_q;
        t_d.pin_prev = cap_pin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // ---------------- timer halves ----------------
    for (genvar g = 0; g < NTMR; g++) begin : g_seg
        gpt_segment #(.SEG_W(SEG_W)) u_seg (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (inc[g]),
            .restart  (restart[g]),
            .cap_load (cap_load[g]),
            .set_ref  (set_ref[g]),
            .set_cap  (set_cap[g]),
            .wr_mode  (wr_mode[g]),
            .mode_wd  (mode_t'(bus_wdata[2:0])),
            .wr_evt   (wr_evt[g]),
            .evt_clr  (bus_wdata[1:0]),
            .wr_ref   (wr_ref[g]),
            .wr_cnt   (wr_cnt[g]),
            .wd       (seg_wd[g]),
            .cnt_o    (cnt_v[g]),
            .ref_o    (ref_v[g]),
            .cap_o    (cap_v[g]),
            .mode_o   (mode_v[g]),
            .evt_o    (evt_v[g])
        );

        assign irq[g] = is_gov[g] && mode_v[g].irq_en && (evt_v[g] != '0);
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        case (cls)
            RC_CFG: begin
                if (tsel == 2'd0)      bus_rdata[0]   = pair_lo;
                else if (tsel == 2'd1) bus_rdata[1:0] = {chain_all, pair_hi};
            end
            RC_MODE: bus_rdata[2:0] = mode_v[tsel];
            RC_EVT:  bus_rdata[1:0] = evt_v[tsel];
            RC_REF:  bus_rdata = wide[tsel] ? {ref_v[tsel], ref_v[tsel_hi]}
                                            : {{SEG_W{1'b0}}, ref_v[tsel]};
            RC_CAP:  bus_rdata = wide[tsel] ? {cap_v[tsel], cap_v[tsel_hi]}
                                            : {{SEG_W{1'b0}}, cap_v[tsel]};
            RC_CNT:  bus_rdata = wide[tsel] ? {cnt_v[tsel], cnt_v[tsel_hi]}
                                            : {{SEG_W{1'b0}}, cnt_v[tsel]};
            default: bus_rdata = '0;
        endcase
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq == '0));

    for (genvar k = 0; k < NTMR - 1; k++) begin : g_chk
        // R3/R4: a chained upper half holds unless the half below rolls over
        a_r3_carry_gate: assert property (@(posedge clk) disable iff (!rst_n)
            (link[k] && !bus_wr && (cnt_v[k+1] != '1) && !restart[k])
            |=> $stable(cnt_v[k]));
    end

    for (genvar k = 0; k < NTMR; k++) begin : g_evchk
        a_r5_follower_events_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_gov[k] && !bus_wr) |=> $stable(evt_v[k]));
    end
endmodule

// File: tb/gptimer_quad_test.sv
module gptimer_quad_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  cap_pin = '0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gptimer_quad uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_pin(cap_pin),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [2:0] C_CFG = 3'd0, C_MODE = 3'd1, C_EVT = 3'd2,
                           C_REF = 3'd3, C_CAP = 3'd4, C_CNT = 3'd5;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    event  sample_ev;

    function automatic logic [4:0] ad(input logic [2:0] c, input int t);
        return {c, 2'(t)};
    endfunction

    // monitor: pops expected items and compares them with the outputs
    always @(sample_ev) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {28'd0, irq} : bus_rdata;
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        sb.push_back('{1'b0, e, tag});
        #2 -> sample_ev;
        #1;
    endtask

    task automatic chk_irq(input logic [3:0] e, input string tag);
        @(negedge clk);
        sb.push_back('{1'b1, {28'd0, e}, tag});
        #2 -> sample_ev;
        #1;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pin(input int i, input logic v);
        @(negedge clk);
        cap_pin[i] = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd(ad(C_CNT, 0), 32'h0, "R1 counter t1");
        chk_rd(ad(C_CNT, 3), 32'h0, "R1 counter t4");
        chk_rd(ad(C_MODE, 1), 32'h0, "R1 mode t2");
        chk_rd(ad(C_CFG, 1), 32'h0, "R1 config word 1");
        chk_irq(4'h0, "R1 irq after reset");

        // R2 independent counting and wrap
        wr(ad(C_REF, 0), 32'h0000_FFFF);
        wr(ad(C_MODE, 0), 32'h1);
        ticks(5);
        chk_rd(ad(C_CNT, 0), 32'h5, "R2 t1 counts ticks");
        chk_rd(ad(C_CNT, 1), 32'h0, "R2 t2 idle untouched");
        wr(ad(C_REF, 0), 32'h10);
        wr(ad(C_CNT, 0), 32'hFFFE);
        ticks(3);
        chk_rd(ad(C_CNT, 0), 32'h1, "R2 wrap FFFF to 0");
        chk_rd(ad(C_EVT, 0), 32'h0, "R2 wrap raises no flag");

        // R3/R5/R8 pair 1/2
        wr(ad(C_CFG, 0), 32'h1);
        wr(ad(C_MODE, 0), 32'h0);
        wr(ad(C_MODE, 1), 32'h1);
        wr(ad(C_REF, 0), 32'hFFFF_FFFF);
        wr(ad(C_CNT, 0), 32'h0001_FFFE);
        ticks(3);
        chk_rd(ad(C_CNT, 0), 32'h0002_0001, "R3 pair carry into high half");
        chk_rd(ad(C_CNT, 1), 32'h0000_0001, "R8 low half narrow view");
        wr(ad(C_MODE, 0), 32'h1);
        wr(ad(C_MODE, 1), 32'h0);
        ticks(2);
        chk_rd(ad(C_CNT, 0), 32'h0002_0001, "R5 lower mode ignored in pair");

        // R6 full-width match in pair
        wr(ad(C_MODE, 0), 32'h0);
        wr(ad(C_MODE, 1), 32'h1);
        wr(ad(C_REF, 0), 32'h0002_0003);
        ticks(3);
        chk_rd(ad(C_CNT, 0), 32'h0, "R6 pair restart at match");
        chk_rd(ad(C_EVT, 1), 32'h1, "R6 flag in governing event");
        chk_rd(ad(C_EVT, 0), 32'h0, "R6 follower event clear");
        chk_irq(4'h0, "R9 irq masked without enable");
        wr(ad(C_MODE, 0), 32'h4);
        wr(ad(C_MODE, 1), 32'h5);
        chk_irq(4'h2, "R9 irq from governing timer only");
        wr(ad(C_EVT, 1), 32'h1);
        chk_rd(ad(C_EVT, 1), 32'h0, "R9 write one clears");
        chk_irq(4'h0, "R9 irq drops after clear");

        // R7 capture in pair
        wr(ad(C_CNT, 0), 32'h1234_5678);
        pin(0, 1'b1);
        chk_rd(ad(C_CAP, 0), 32'h0, "R7 follower pin ignored");
        pin(1, 1'b1);
        chk_rd(ad(C_CAP, 0), 32'h1234_5678, "R7 pair capture coherent");
        chk_rd(ad(C_EVT, 1), 32'h2, "R7 capture flag");
        chk_irq(4'h2, "R9 irq on capture flag");
        wr(ad(C_EVT, 1), 32'h3);

        // R4 all-four chain
        wr(ad(C_CFG, 1), 32'h2);
        wr(ad(C_REF, 0), 32'hFFFF_FFFF);
        wr(ad(C_REF, 2), 32'hFFFF_FFFF);
        wr(ad(C_CNT, 0), 32'h0000_FFFF);
        wr(ad(C_CNT, 2), 32'hFFFF_FFFE);
        wr(ad(C_MODE, 3), 32'h1);
        ticks(3);
        chk_rd(ad(C_CNT, 0), 32'h0001_0000, "R4 carry through three halves");
        chk_rd(ad(C_CNT, 2), 32'h0000_0001, "R4 low word");
        wr(ad(C_MODE, 3), 32'h0);
        wr(ad(C_MODE, 0), 32'h1);
        wr(ad(C_MODE, 2), 32'h1);
        ticks(2);
        chk_rd(ad(C_CNT, 2), 32'h0000_0001, "R5 only timer 4 mode governs");

        // R6 match in chain of four
        wr(ad(C_REF, 0), 32'h0001_0000);
        wr(ad(C_REF, 2), 32'h0000_0003);
        wr(ad(C_MODE, 3), 32'h1);
        ticks(3);
        chk_rd(ad(C_CNT, 0), 32'h0, "R6 64-bit restart high");
        chk_rd(ad(C_CNT, 2), 32'h0, "R6 64-bit restart low");
        chk_rd(ad(C_EVT, 3), 32'h1, "R6 flag in timer 4");
        chk_irq(4'h0, "R9 follower enable has no effect");

        // R7 capture in chain of four, falling edge
        wr(ad(C_CNT, 0), 32'hAAAA_BBBB);
        wr(ad(C_CNT, 2), 32'hCCCC_DDDD);
        wr(ad(C_MODE, 3), 32'h3);
        pin(1, 1'b0);
        chk_rd(ad(C_EVT, 3), 32'h1, "R7 timer 2 pin ignored in chain");
        pin(3, 1'b1);
        chk_rd(ad(C_CAP, 2), 32'h0, "R7 rising ignored when falling chosen");
        pin(3, 1'b0);
        chk_rd(ad(C_CAP, 0), 32'hAAAA_BBBB, "R7 64-bit capture high");
        chk_rd(ad(C_CAP, 2), 32'hCCCC_DDDD, "R7 64-bit capture low");
        chk_rd(ad(C_EVT, 3), 32'h3, "R7 both flags set");
        wr(ad(C_MODE, 3), 32'h4);
        chk_irq(4'h8, "R9 irq timer 4");
        wr(ad(C_EVT, 3), 32'h1);
        chk_rd(ad(C_EVT, 3), 32'h2, "R9 clear only written bit");
        wr(ad(C_EVT, 3), 32'h2);
        chk_irq(4'h0, "R9 irq cleared");

        // R2/R3/R8 mixed: t1, t2 separate, t3/t4 paired
        wr(ad(C_CFG, 1), 32'h1);
        wr(ad(C_CFG, 0), 32'h0);
        chk_rd(ad(C_CFG, 1), 32'h1, "R8 config word 1 readback");
        chk_rd(ad(C_REF, 0), 32'h0000_0001, "R8 narrow view unchained");
        chk_rd(ad(C_REF, 2), 32'h0000_0003, "R8 pair 3/4 lane order");
        wr(ad(C_CNT, 0), 32'h10);
        wr(ad(C_REF, 0), 32'hFFFF);
        wr(ad(C_REF, 2), 32'hFFFF_FFFF);
        wr(ad(C_CNT, 2), 32'h0000_FFFF);
        wr(ad(C_MODE, 3), 32'h1);
        ticks(2);
        chk_rd(ad(C_CNT, 0), 32'h12, "R2 t1 independent in mixed");
        chk_rd(ad(C_CNT, 1), 32'hBBBD, "R2 t2 independent in mixed");
        chk_rd(ad(C_CNT, 2), 32'h0001_0001, "R3 pair 3/4 carry");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule